// File: doc/BRIEF.md
# Protected RAM Loader and Background Scrubber

This block sits between a processor, a code ROM and a RAM whose words carry error-correcting check bits. After reset it streams the ROM image into the RAM, computing the check bits as each word is written, so that every location holds a consistent codeword before the processor may touch memory. A busy flag covers the whole copy.

Once the copy is done, processor accesses pass through the block. Writes are encoded and reads are corrected on the way back, with a flag for words that cannot be repaired. Whenever the processor leaves the RAM alone, the block walks the address space one word at a time. It reads each word, corrects it and writes the clean codeword back, so that a lone upset is removed before a second one can land in the same word. A programmable gap sets the spacing between scrubbed words, which allows a tighter sweep when upsets are expected more often. A scrub step never delays the processor by more than one cycle. An interrupted step is dropped whole and repeated at the same address. Two saturating counters record how many correctable and how many uncorrectable words have been seen.

Top module: `mem_scrub_seq`

## Requirements
- R1: While reset is held, busy is high and both error counters read zero. After release, ROM word k (the ROM returns data one cycle after its address) is encoded and written to RAM address k for every k. Busy falls on the DEPTH+1-th rising edge after release.
- R2: cpu_gnt is never high while busy is high.
- R3: A codeword holds the data in bits [DW-1:0], the check bits in [DW+CW-1:DW], and an overall even-parity bit in the top bit NW-1. A granted CPU write stores the encoding of cpu_wdata. A granted CPU read raises cpu_rvalid and presents the data in the cycle after the grant.
- R4: A stored word with any one bit flipped (data, check or parity bit) reads back as the original data, and each such read adds one to sec_cnt.
- R5: A stored word with two bits flipped raises cpu_ded together with cpu_rvalid, and each such read adds one to ded_cnt.
- R6: A scrub step reads a word and, in the next cycle, writes the corrected codeword back to the same address, which repairs a single flipped bit in RAM.
- R7: Completed scrub write-backs go through ascending addresses and wrap from DEPTH-1 to 0.
- R8: With the CPU quiet, successive scrub write-backs are scrub_gap+3 cycles apart. The gap counts only cycles without a CPU request.
- R9: A CPU request that is not granted in its first cycle is granted in the next one. A scrub step cut short by a request writes nothing, and the same address is scrubbed again later.
- R10: A scrub read that finds a double error writes nothing back, adds one to ded_cnt and moves on to the next address.
- R11: sec_cnt and ded_cnt stop at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scrub_gap | input | GW | Idle cycles between scrub steps |
| busy | output | 1 | High until the startup copy completes |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_gnt | output | 1 | Access taken this cycle |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DW | Corrected read data |
| cpu_ded | output | 1 | Read word holds an uncorrectable error |
| rom_addr | output | AW | ROM word address |
| rom_data | input | DW | ROM data, one cycle after address |
| ram_addr | output | AW | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | NW | Codeword to RAM |
| ram_rdata | input | NW | Codeword from RAM, one cycle after address |
| sec_cnt | output | CNTW | Corrected single errors, saturating |
| ded_cnt | output | CNTW | Detected double errors, saturating |

## Verification
Reads are tried on clean words, on words with one flipped bit placed in the data field, in the check field and on the parity bit, and on words with two flips across those fields. This separates correct decoding from false correction and from missed detection. Scrubbing is run with the processor quiet at two gap settings, which pins down the spacing, the address order and the wrap. It is then run against a burst of processor reads and writes, which shows whether cut-short steps are retried at the same address without ever overwriting processor data. A planted double error shows that such a word is left as found, not rewritten.

// File: rtl/mem_scrub_seq.sv
module mem_scrub_seq #(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int CNTW = 4,
  localparam int CW  = (DW <= 4) ? 3 : (DW <= 11) ? 4 : (DW <= 26) ? 5 : (DW <= 57) ? 6 : 7,
  localparam int NW  = DW + CW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [GW-1:0]   scrub_gap,
  output logic            busy,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_gnt,
  output logic            cpu_rvalid,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_ded,
  output logic [AW-1:0]   rom_addr,
  input  logic [DW-1:0]   rom_data,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_we,
  output logic [NW-1:0]   ram_wdata,
  input  logic [NW-1:0]   ram_rdata,
  output logic [CNTW-1:0] sec_cnt,
  output logic [CNTW-1:0] ded_cnt
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CNTW-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_CP, S_IDLE, S_SRD, S_SWB} st_t;

  function automatic logic [CW-1:0] pos_of(input int i);
    int k;
    pos_of = '0;
    k = 0;
    for (int q = 3; q < (1 << CW); q++)
      if ((q & (q - 1)) != 0) begin
        if (k == i) pos_of = CW'(q);
        k++;
      end
  endfunction

  function automatic logic [CW-1:0] chk_of(input logic [DW-1:0] d);
    chk_of = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) chk_of ^= pos_of(i);
  endfunction

  function automatic logic [NW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = chk_of(d);
    enc = {^{c, d}, c, d};
  endfunction

  st_t             st;
  logic [AW:0]     cp_addr;
  logic [AW-1:0]   sc_addr;
  logic [GW-1:0]   gap_cnt;
  logic [DW-1:0]   rd_data, fix_data;
  logic [CW-1:0]   syn;
  logic            perr, dec_sec, dec_ded;

  assign rd_data = ram_rdata[DW-1:0];
  assign syn     = ram_rdata[DW+CW-1:DW] ^ chk_of(rd_data);
  assign perr    = ^ram_rdata;
  assign dec_sec = perr;
  assign dec_ded = !perr && (syn != '0);

  always_comb begin
    fix_data = rd_data;
    for (int i = 0; i < DW; i++)
      if (perr && syn == pos_of(i)) fix_data[i] = ~rd_data[i];
  end

  wire idle     = (st == S_IDLE);
  wire go_scrub = idle && !cpu_req && (gap_cnt >= scrub_gap);
  wire wb_done  = (st == S_SWB) && !cpu_req;
  wire cnt_ev   = wb_done || cpu_rvalid;

  assign busy      = (st == S_CP);
  assign cpu_gnt   = cpu_req && idle;
  assign cpu_rdata = fix_data;
  assign cpu_ded   = cpu_rvalid && dec_ded;
  assign rom_addr  = cp_addr[AW-1:0];

  always_comb begin
    case (st)
      S_CP: begin
        ram_addr  = cp_addr[AW-1:0] - 1'b1;
        ram_we    = (cp_addr != '0);
        ram_wdata = enc(rom_data);
      end
      S_IDLE: begin
        ram_addr  = cpu_addr;
        ram_we    = cpu_gnt && cpu_we;
        ram_wdata = enc(cpu_wdata);
      end
      default: begin
        ram_addr  = sc_addr;
        ram_we    = wb_done && !dec_ded;
        ram_wdata = enc(fix_data);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_CP;
      cp_addr    <= '0;
      sc_addr    <= '0;
      gap_cnt    <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_gnt && !cpu_we;
      case (st)
        S_CP: begin
          cp_addr <= cp_addr + 1'b1;
          if (cp_addr == (AW+1)'(DEPTH)) st <= S_IDLE;
        end
        S_IDLE: begin
          if (go_scrub) st <= S_SRD;
          else if (!cpu_req && gap_cnt < scrub_gap) gap_cnt <= gap_cnt + 1'b1;
        end
        S_SRD: st <= cpu_req ? S_IDLE : S_SWB;
        default: begin
          st <= S_IDLE;
          if (!cpu_req) begin
            sc_addr <= sc_addr + 1'b1;
            gap_cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      ded_cnt <= '0;
    end else if (cnt_ev) begin
      if (dec_sec && sec_cnt != CMAX) sec_cnt <= sec_cnt + 1'b1;
      if (dec_ded && ded_cnt != CMAX) ded_cnt <= ded_cnt + 1'b1;
    end
  end

  // R1
  copy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(ram_we) && $past(ram_addr) == {AW{1'b1}}));

  // R2
  gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cpu_gnt);

  // R6
  wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !busy && !cpu_gnt) |-> (ram_addr == $past(ram_addr)));

  // R9
  gnt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !busy && !cpu_gnt) |=> (cpu_gnt || !cpu_req));

  // R11
  sec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_cnt == CMAX) |=> (sec_cnt == CMAX));

  // R11
  ded_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_cnt == CMAX) |=> (ded_cnt == CMAX));
endmodule

// File: tb/mem_scrub_seq_tb.sv
module mem_scrub_seq_tb;
  localparam int AW = 6, DW = 16, GW = 16, CNTW = 4, NW = 22, DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic [GW-1:0] scrub_gap = '1;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic busy, cpu_gnt, cpu_rvalid, cpu_ded, ram_we;
  logic [DW-1:0] cpu_rdata, rom_data;
  logic [AW-1:0] rom_addr, ram_addr;
  logic [NW-1:0] ram_wdata, ram_rdata;
  logic [CNTW-1:0] sec_cnt, ded_cnt;

  always #2 clk = ~clk;

  mem_scrub_seq #(.AW(AW), .DW(DW), .GW(GW), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scrub_gap(scrub_gap), .busy(busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_ded(cpu_ded),
    .rom_addr(rom_addr), .rom_data(rom_data), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .sec_cnt(sec_cnt), .ded_cnt(ded_cnt));

  function automatic logic [DW-1:0] rom_img(input logic [AW-1:0] a);
    logic [DW-1:0] t;
    t = {10'd0, a} * 16'h3b9d;
    return t ^ 16'hc35a;
  endfunction

  logic [NW-1:0] mem [DEPTH];
  logic [NW-1:0] golden [DEPTH];
  logic inj_en = 0;
  logic [AW-1:0] inj_a = '0;
  logic [NW-1:0] inj_m = '0;

  always @(posedge clk) begin
    rom_data <= rom_img(rom_addr);
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (inj_en) mem[inj_a] <= mem[inj_a] ^ inj_m;
    ram_rdata <= mem[ram_addr];
  end

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scrub write-back monitor
  bit mon_on = 0, mon_gchk = 0, have = 0, wrap_seen = 0;
  int mon_gap = 0, last_t = 0, step_bad = 0, gap_bad = 0;
  logic [AW-1:0] last_a = '0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (!mon_on) have = 0;
    else if (ram_we && !busy && !cpu_gnt) begin
      if (have) begin
        if (ram_addr != last_a + 1'b1) step_bad++;
        if (last_a == '1 && ram_addr == '0) wrap_seen = 1;
        if (mon_gchk && (cyc - last_t) != mon_gap + 3) gap_bad++;
      end
      have = 1;
      last_a = ram_addr;
      last_t = cyc;
    end
  end

  task automatic inject(input logic [AW-1:0] a, input logic [NW-1:0] m);
    @(negedge clk);
    inj_a = a; inj_m = m; inj_en = 1;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output logic dd, output logic rv, output int waits);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; waits = 0;
    #1;
    while (!cpu_gnt && waits < 100) begin
      @(negedge clk); #1; waits++;
    end
    @(negedge clk);
    rd = cpu_rdata; dd = cpu_ded; rv = cpu_rvalid;
    cpu_req = 0; cpu_we = 0;
  endtask

  // {addr[5:0], nflip[1:0], bitA[4:0], bitB[4:0], exp_ded}
  localparam logic [18:0] VEC [10] = '{
    {6'd3,  2'd0, 5'd0,  5'd0,  1'b0},
    {6'd7,  2'd1, 5'd0,  5'd0,  1'b0},
    {6'd12, 2'd1, 5'd15, 5'd0,  1'b0},
    {6'd20, 2'd1, 5'd17, 5'd0,  1'b0},
    {6'd33, 2'd1, 5'd21, 5'd0,  1'b0},
    {6'd63, 2'd1, 5'd9,  5'd0,  1'b0},
    {6'd0,  2'd2, 5'd0,  5'd1,  1'b1},
    {6'd40, 2'd2, 5'd4,  5'd18, 1'b1},
    {6'd50, 2'd2, 5'd16, 5'd21, 1'b1},
    {6'd5,  2'd2, 5'd10, 5'd21, 1'b1}
  };

  initial begin
    logic [DW-1:0] rd;
    logic dd, rv;
    int w, n, gseen, nsec, nded;
    logic [DW-1:0] exp_d [DEPTH];
    logic [NW-1:0] badw;

    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1, "R1", busy, 1);
    chk(sec_cnt == 0 && ded_cnt == 0, "R1", {sec_cnt, ded_cnt}, 0);
    chk(cpu_rvalid == 0, "R3", cpu_rvalid, 0);

    // copy, with a pending request that must wait (R2)
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 6'd1;
    rst_n = 1;
    n = 0; gseen = 0;
    do begin
      @(posedge clk); #1; n++;
      if (busy && cpu_gnt) gseen++;
    end while (busy && n < 500);
    chk(n == DEPTH + 1, "R1", n, DEPTH + 1);
    chk(gseen == 0, "R2", gseen, 0);
    chk(cpu_gnt == 1, "R9", cpu_gnt, 1);
    @(negedge clk); cpu_req = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) golden[i] = mem[i];

    n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      cpu_op(0, AW'(i), '0, rd, dd, rv, w);
      exp_d[i] = rom_img(AW'(i));
      if (rd !== exp_d[i] || !rv || dd) begin
        n++;
        $display("FAIL R1 addr=%0d act=%0h exp=%0h", i, rd, exp_d[i]);
      end
    end
    total++; if (n != 0) bad++;

    // vector table: reads of clean, single and double flipped words
    nsec = 0; nded = 0;
    for (int v = 0; v < 10; v++) begin
      logic [18:0] e;
      logic [AW-1:0] a;
      logic [NW-1:0] m;
      e = VEC[v];
      a = e[18:13];
      m = '0;
      if (e[12:11] >= 1) m[e[10:6]] = 1'b1;
      if (e[12:11] == 2) m[e[5:1]] = 1'b1;
      if (m != '0) inject(a, m);
      cpu_op(0, a, '0, rd, dd, rv, w);
      chk(rv == 1, "R3", rv, 1);
      chk(dd == e[0], "R5", dd, e[0]);
      if (!e[0]) chk(rd == rom_img(a), (e[12:11] == 0) ? "R3" : "R4", rd, rom_img(a));
      if (e[12:11] == 1) nsec++;
      if (e[0]) nded++;
      cpu_op(1, a, rom_img(a), rd, dd, rv, w);
      chk(mem[a] == golden[a], "R3", mem[a], golden[a]);
    end
    chk(sec_cnt == CNTW'(nsec), "R4", sec_cnt, nsec);
    chk(ded_cnt == CNTW'(nded), "R5", ded_cnt, nded);

    // saturation of the single-error counter
    inject(6'd9, 22'h4);
    for (int k = 0; k < 20; k++) cpu_op(0, 6'd9, '0, rd, dd, rv, w);
    chk(sec_cnt == 4'hf, "R11", sec_cnt, 4'hf);
    chk(rd == rom_img(6'd9), "R4", rd, rom_img(6'd9));
    cpu_op(1, 6'd9, rom_img(6'd9), rd, dd, rv, w);

    // scrub repair, ordering, wrap and spacing with gap 5
    inject(6'd10, 22'h8);
    inject(6'd62, 22'h80000);
    mon_gap = 5; mon_gchk = 1; mon_on = 1;
    @(negedge clk); scrub_gap = 16'd5;
    repeat (600) @(negedge clk);
    mon_on = 0; scrub_gap = '1;
    repeat (10) @(negedge clk);
    chk(mem[10] == golden[10], "R6", mem[10], golden[10]);
    chk(mem[62] == golden[62], "R6", mem[62], golden[62]);
    chk(step_bad == 0, "R7", step_bad, 0);
    chk(wrap_seen == 1, "R7", wrap_seen, 1);
    chk(gap_bad == 0, "R8", gap_bad, 0);
    chk(sec_cnt == 4'hf, "R11", sec_cnt, 4'hf);

    // spacing with gap 0
    mon_gap = 0; mon_on = 1;
    @(negedge clk); scrub_gap = 16'd0;
    repeat (250) @(negedge clk);
    mon_on = 0; scrub_gap = '1;
    repeat (10) @(negedge clk);
    chk(gap_bad == 0, "R8", gap_bad, 0);
    n = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != golden[i]) n++;
    chk(n == 0, "R6", n, 0);

    // double error met by the scrubber
    inject(6'd30, 22'h6);
    badw = golden[30] ^ 22'h6;
    @(negedge clk); scrub_gap = 16'd0;
    repeat (250) @(negedge clk);
    scrub_gap = '1;
    repeat (10) @(negedge clk);
    chk(mem[30] == badw, "R10", mem[30], badw);
    chk(ded_cnt > CNTW'(nded), "R10", ded_cnt, nded + 1);
    n = 0;
    for (int i = 0; i < DEPTH; i++) if (i != 30 && mem[i] != golden[i]) n++;
    chk(n == 0, "R10", n, 0);
    cpu_op(1, 6'd30, rom_img(6'd30), rd, dd, rv, w);

    // CPU traffic cutting into scrub steps
    mon_gchk = 0; step_bad = 0; mon_on = 1;
    @(negedge clk); scrub_gap = 16'd0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      a = AW'(k * 7 + 3);
      if (k % 2 == 0) begin
        exp_d[a] = DW'(k * 16'h1111) ^ 16'h0f0f;
        cpu_op(1, a, exp_d[a], rd, dd, rv, w);
      end else
        cpu_op(0, a, '0, rd, dd, rv, w);
      if (w > 1) n++;
      repeat (k % 4) @(negedge clk);
    end
    chk(n == 0, "R9", n, 0);
    repeat (20) @(negedge clk);
    mon_on = 0; scrub_gap = '1;
    repeat (10) @(negedge clk);
    chk(step_bad == 0, "R9", step_bad, 0);
    n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      cpu_op(0, AW'(i), '0, rd, dd, rv, w);
      if (rd !== exp_d[i] || dd) n++;
    end
    chk(n == 0, "R9", n, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule